// File: doc/BRIEF.md
# Three-Wire Control Slave with Inverted Output Port

This block is the control front end of a frequency-synthesis chip. A host
controller reaches it over three wires: a select line, a serial clock and a
data line in. A fourth wire, data out, returns a status word. While the select
line is high, each rising serial-clock edge shifts one control bit in, most
significant bit first. The new word takes effect only when the select line
falls after exactly the full frame length. On that select edge the fields are
copied into the frequency, prescaler-mode, input-select and time-base controls
and into seven port bits. In the same select window, a status word captured
when select rose is shifted out, one bit per falling serial-clock edge.

All serial pins are asynchronous to the system clock. They pass through
two-flop synchronizers and edge detectors before the frame logic uses them.
The seven port pins show the inverted port bits. Pin 0 can instead carry an
external time-base signal. Pins 1 and 2 are push-pull drivers and the others
are open-drain. Until the first valid frame arrives, every pin is released.

Top module: `serctl_port`

## Requirements
- R1: After reset, cfg_div, cfg_dv, cfg_sp and cfg_tb are 0, port_val is all ones, port_oe is all zeros and ser_dout is 0.
- R2: With ser_sel high, ser_din is sampled on each rising ser_clk, MSB first. When ser_sel falls after exactly 36 bits, the 36-bit frame commits with port bit i at frame bit i (bits 6..0), time-base select at bit 7, prescaler mode at bit 8, input select at bit 9 and the divisor at bits 25..10. Bits 35..26 are ignored.
- R3: A select window with any bit count other than 36 leaves every control output and port output unchanged. A pure read window is one example.
- R4: ser_clk and ser_din activity while ser_sel is low has no effect. A later correct frame commits as if that activity had never happened.
- R5: The 28-bit status_in is captured when ser_sel rises, and its MSB appears on ser_dout. Each falling ser_clk moves the next lower bit out. After all 28 bits, ser_dout reads 0. While ser_sel is low, ser_dout is 0.
- R6: With time-base select 0, port_val[i] equals the inverse of committed port bit i for every pin.
- R7: With time-base select 1, port_val[0] follows tb_in, and pins 1..6 keep showing their inverted port bits.
- R8: Before the first committed frame, port_oe is all zeros. After it, pins 1 and 2 have port_oe = 1, and each other pin has port_oe = 1 exactly when its port_val is 0 (open-drain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel | input | 1 | Serial frame select, high during a transfer |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial control data from the host |
| ser_dout | output | 1 | Serial status data to the host |
| tb_in | input | 1 | Time-base signal that can replace port pin 0 |
| status_in | input | 28 | Status word to be returned |
| cfg_dv | output | 1 | Committed input-select flag |
| cfg_sp | output | 1 | Committed prescaler-mode flag |
| cfg_tb | output | 1 | Committed time-base select |
| cfg_div | output | 16 | Committed divisor setting |
| port_val | output | 7 | Logic level presented on each port pin |
| port_oe | output | 7 | Drive enable for each port pin |

## Verification
The assertions assume that the serial pins change slowly compared with the
system clock. Each level must hold for at least three system cycles, so that
every edge is seen once through the synchronizers. They also assume that
ser_din is settled before the rising ser_clk that samples it and that select
and clock never change together. The bench drives every serial half-period as
six system cycles. It changes data only while ser_clk is low, and it moves
select only with ser_clk low and after a full half-period of settling.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
   localparam int DEF_CTRL_W = 36;
   localparam int DEF_STAT_W = 28;
   localparam int DEF_DIV_W  = 16;
   localparam int DEF_PORT_N = 7;
   // flag fields sit just above the port bits, in this order
   localparam int OFS_TB  = 0;
   localparam int OFS_SP  = 1;
   localparam int OFS_DV  = 2;
   localparam int N_FLAGS = 3;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] ff1, ff2, prev;

   generate
      if (N < 1) begin : g_bad_n
         $error("serctl_sync: N must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ff1  <= '0;
         ff2  <= '0;
         prev <= '0;
      end else begin
         ff1  <= d;
         ff2  <= ff1;
         prev <= ff2;
      end
   end

   assign q    = ff2;
   assign rise = ff2 & ~prev;
   assign fall = ~ff2 & prev;
endmodule

// File: rtl/serctl_rx.sv
module serctl_rx #(
   parameter int CTRL_W = 36,
   parameter int KEEP_W = 26,
   localparam int LIM   = CTRL_W + 1,
   localparam int CNT_W = $clog2(CTRL_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_lvl,
   input  logic              sel_rise,
   input  logic              sel_fall,
   input  logic              sclk_rise,
   input  logic              din_raw,
   output logic [KEEP_W-1:0] word,
   output logic              valid
);
   logic              din_s1, din_s2;
   logic [KEEP_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;

   generate
      if (KEEP_W < 2 || KEEP_W > CTRL_W) begin : g_bad_keep
         $error("serctl_rx: KEEP_W must lie in 2..CTRL_W");
      end
   endgenerate

   // data path delayed to match the clock synchronizer depth
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         din_s1 <= 1'b0;
         din_s2 <= 1'b0;
      end else begin
         din_s1 <= din_raw;
         din_s2 <= din_s1;
      end
   end

   // bits older than KEEP_W positions carry no field and fall off the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (sel_rise) begin
         cnt <= '0;
      end else if (sel_lvl && sclk_rise) begin
         shreg <= {shreg[KEEP_W-2:0], din_s2};
         if (cnt != CNT_W'(LIM)) cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         valid <= 1'b0;
      end else if (sel_fall && cnt == CNT_W'(CTRL_W)) begin
         word  <= shreg;
         valid <= 1'b1;
      end
   end

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(LIM));
   assert_short_long_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_fall && cnt != CNT_W'(CTRL_W)) |=> $stable(word));
   assert_no_commit_midframe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_fall |=> $stable(word) && $stable(valid));
   assert_idle_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_lvl |=> $stable(shreg));
endmodule

// File: rtl/serctl_tx.sv
module serctl_tx #(
   parameter int STAT_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_lvl,
   input  logic              sel_rise,
   input  logic              sclk_fall,
   input  logic [STAT_W-1:0] status_in,
   output logic              dout
);
   logic [STAT_W-1:0] shreg;

   generate
      if (STAT_W < 2) begin : g_bad_stat
         $error("serctl_tx: STAT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (sel_rise) begin
         shreg <= status_in;
      end else if (sel_lvl && sclk_fall) begin
         shreg <= {shreg[STAT_W-2:0], 1'b0};
      end
   end

   assign dout = sel_lvl & shreg[STAT_W-1];

   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rise |=> shreg == $past(status_in));
   assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_lvl && sclk_fall && !sel_rise) |=> !shreg[0]);
endmodule

// File: rtl/serctl_portdrv.sv
module serctl_portdrv #(
   parameter int                 PORT_N  = 7,
   parameter logic [PORT_N-1:0]  PP_MASK = 7'b0000110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [PORT_N-1:0] port_bits,
   input  logic              tb_sel,
   input  logic              tb_in,
   output logic [PORT_N-1:0] pin_val,
   output logic [PORT_N-1:0] pin_oe
);
   generate
      for (genvar i = 0; i < PORT_N; i++) begin : g_pin
         if (i == 0) begin : g_val_tb
            assign pin_val[i] = tb_sel ? tb_in : ~port_bits[i];
         end else begin : g_val_plain
            assign pin_val[i] = ~port_bits[i];
         end
         if (PP_MASK[i]) begin : g_pushpull
            assign pin_oe[i] = valid;
         end else begin : g_opendrain
            assign pin_oe[i] = valid & ~pin_val[i];
         end
      end
   endgenerate

   assert_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> pin_oe == '0);
   assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid);
endmodule

// File: rtl/serctl_port.sv
module serctl_port
   import serctl_pkg::*;
#(
   parameter int                CTRL_W  = DEF_CTRL_W,
   parameter int                STAT_W  = DEF_STAT_W,
   parameter int                DIV_W   = DEF_DIV_W,
   parameter int                PORT_N  = DEF_PORT_N,
   parameter logic [PORT_N-1:0] PP_MASK = 7'b0000110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sel,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic              ser_dout,
   input  logic              tb_in,
   input  logic [STAT_W-1:0] status_in,
   output logic              cfg_dv,
   output logic              cfg_sp,
   output logic              cfg_tb,
   output logic [DIV_W-1:0]  cfg_div,
   output logic [PORT_N-1:0] port_val,
   output logic [PORT_N-1:0] port_oe
);
   localparam int POS_TB  = PORT_N + OFS_TB;
   localparam int POS_SP  = PORT_N + OFS_SP;
   localparam int POS_DV  = PORT_N + OFS_DV;
   localparam int DIV_LSB = PORT_N + N_FLAGS;
   localparam int KEEP_W  = DIV_LSB + DIV_W;

   generate
      if (KEEP_W > CTRL_W) begin : g_bad_layout
         $error("serctl_port: fields do not fit in CTRL_W");
      end
   endgenerate

   logic [1:0]        s_lvl, s_rise, s_fall;
   logic [KEEP_W-1:0] word;
   logic              valid;

   serctl_sync #(.N(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_sel, ser_clk}),
      .q    (s_lvl),
      .rise (s_rise),
      .fall (s_fall)
   );

   serctl_rx #(.CTRL_W(CTRL_W), .KEEP_W(KEEP_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_lvl  (s_lvl[1]),
      .sel_rise (s_rise[1]),
      .sel_fall (s_fall[1]),
      .sclk_rise(s_rise[0]),
      .din_raw  (ser_din),
      .word     (word),
      .valid    (valid)
   );

   serctl_tx #(.STAT_W(STAT_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_lvl  (s_lvl[1]),
      .sel_rise (s_rise[1]),
      .sclk_fall(s_fall[0]),
      .status_in(status_in),
      .dout     (ser_dout)
   );

   assign cfg_tb  = word[POS_TB];
   assign cfg_sp  = word[POS_SP];
   assign cfg_dv  = word[POS_DV];
   assign cfg_div = word[DIV_LSB +: DIV_W];

   serctl_portdrv #(.PORT_N(PORT_N), .PP_MASK(PP_MASK)) u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (valid),
      .port_bits(word[PORT_N-1:0]),
      .tb_sel   (cfg_tb),
      .tb_in    (tb_in),
      .pin_val  (port_val),
      .pin_oe   (port_oe)
   );

   assert_idle_dout_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !s_lvl[1] |-> !ser_dout);
   assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !s_fall[1] |=> $stable(cfg_div) && $stable(cfg_tb));
endmodule

// File: tb/serctl_port_bench.sv
`timescale 1ns/1ps
module serctl_port_bench;
   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_sel = 1'b0, ser_clk = 1'b0, ser_din = 1'b0, tb_in = 1'b0;
   logic [27:0] status_in = '0;
   logic        ser_dout, cfg_dv, cfg_sp, cfg_tb;
   logic [15:0] cfg_div;
   logic [6:0]  port_val, port_oe;

   int total = 0;
   int bad = 0;
   bit done_flag = 1'b0;

   string       req_q[$];
   int          kind_q[$];
   logic [63:0] exp_q[$];
   event        mon_ev;

   logic [35:0] model_word = '0;
   bit          model_valid = 1'b0;

   always #2.5 clk = ~clk;

   serctl_port u_serctl_port (
      .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
      .ser_din(ser_din), .ser_dout(ser_dout), .tb_in(tb_in),
      .status_in(status_in), .cfg_dv(cfg_dv), .cfg_sp(cfg_sp),
      .cfg_tb(cfg_tb), .cfg_div(cfg_div), .port_val(port_val),
      .port_oe(port_oe)
   );

   function automatic logic [35:0] mk(input logic [15:0] dv_div, input logic dv,
      input logic sp, input logic tb, input logic [6:0] pb, input logic [9:0] junk);
      return {junk, dv_div, dv, sp, tb, pb};
   endfunction

   function automatic logic [63:0] exp_snap();
      logic [6:0] v, oe;
      v = ~model_word[6:0];
      if (model_word[7]) v[0] = tb_in;
      for (int i = 0; i < 7; i++)
         oe[i] = model_valid ? ((i == 1 || i == 2) ? 1'b1 : ~v[i]) : 1'b0;
      return {31'b0, model_word[25:10], model_word[9], model_word[8],
              model_word[7], v, oe};
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_item(input string r, input int k, input logic [63:0] e);
      req_q.push_back(r);
      kind_q.push_back(k);
      exp_q.push_back(e);
      ->mon_ev;
      @(negedge clk);
   endtask

   // monitor: pops expected items and compares with what the design shows
   initial begin
      forever begin
         @(mon_ev);
         while (exp_q.size() > 0) begin
            string       r;
            int          k;
            logic [63:0] e, got;
            r = req_q.pop_front();
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            if (k == 0) got = {31'b0, cfg_div, cfg_dv, cfg_sp, cfg_tb, port_val, port_oe};
            else        got = {63'b0, ser_dout};
            total++;
            if (got !== e) begin
               bad++;
               $display("FAIL %s got=%h exp=%h", r, got, e);
            end
         end
      end
   end

   task automatic ser_write(input logic [63:0] val, input int nbits);
      ser_sel = 1'b1;
      wait_clk(HALF);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_din = val[i];
         wait_clk(HALF);
         ser_clk = 1'b1;
         wait_clk(HALF);
         ser_clk = 1'b0;
      end
      wait_clk(HALF);
      ser_sel = 1'b0;
      wait_clk(2 * HALF);
   endtask

   task automatic ser_read(input logic [27:0] st, input int nbits, input string r);
      status_in = st;
      wait_clk(2);
      ser_sel = 1'b1;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         expect_item(r, 1, (i < 28) ? {63'b0, st[27 - i]} : 64'b0);
         ser_clk = 1'b1;
         wait_clk(HALF);
         ser_clk = 1'b0;
         wait_clk(HALF);
      end
      ser_sel = 1'b0;
      wait_clk(2 * HALF);
      expect_item({r, " idle"}, 1, 64'b0);
   endtask

   initial begin
      logic [35:0] w;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      expect_item("R1 reset outputs", 0, exp_snap());
      expect_item("R1 reset dout", 1, 64'b0);

      w = mk(16'h1234, 1'b0, 1'b0, 1'b0, 7'b1010101, 10'h3A5);
      ser_write({28'b0, w}, 36);
      model_word = w; model_valid = 1'b1;
      expect_item("R2 R6 R8 first frame", 0, exp_snap());

      w = mk(16'hBEEF, 1'b1, 1'b1, 1'b0, 7'b0110011, 10'h000);
      ser_write({28'b0, w}, 36);
      model_word = w;
      expect_item("R2 R6 second frame", 0, exp_snap());

      ser_write({28'b0, mk(16'h5555, 1'b0, 1'b0, 1'b1, 7'b0000000, 10'h0)}, 35);
      expect_item("R3 35-bit frame dropped", 0, exp_snap());
      ser_write({27'b0, 1'b1, mk(16'h0F0F, 1'b0, 1'b1, 1'b0, 7'b1111000, 10'h0)}, 37);
      expect_item("R3 37-bit frame dropped", 0, exp_snap());

      for (int i = 0; i < 40; i++) begin
         ser_din = i[0] ^ i[2];
         wait_clk(HALF);
         ser_clk = 1'b1;
         wait_clk(HALF);
         ser_clk = 1'b0;
      end
      expect_item("R4 clocks while deselected", 0, exp_snap());
      expect_item("R4 dout while deselected", 1, 64'b0);

      w = mk(16'h0100, 1'b0, 1'b1, 1'b1, 7'b1111110, 10'h2C1);
      ser_write({28'b0, w}, 36);
      model_word = w;
      tb_in = 1'b0;
      wait_clk(2);
      expect_item("R4 R7 time base low", 0, exp_snap());
      tb_in = 1'b1;
      wait_clk(2);
      expect_item("R7 time base high", 0, exp_snap());
      tb_in = 1'b0;

      w = mk(16'hFFFF, 1'b1, 1'b0, 1'b0, 7'b0000000, 10'h3FF);
      ser_write({28'b0, w}, 36);
      model_word = w;
      expect_item("R6 R8 all ports released high", 0, exp_snap());

      ser_read(28'hA5C396E, 30, "R5 status read A");
      expect_item("R3 read window kept config", 0, exp_snap());
      ser_read(28'h5A3C691, 28, "R5 status read B");

      w = mk(16'h8001, 1'b0, 1'b0, 1'b0, 7'b1001001, 10'h155);
      ser_write({28'b0, w}, 36);
      model_word = w;
      expect_item("R2 R8 frame after read", 0, exp_snap());

      wait_clk(4);
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         total++;
         bad++;
         $display("FAIL watchdog got=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule